// File: doc/BRIEF.md
# Streaming Adaptive Binarizer with Tile Counter

This block turns a raster stream of 8-bit grayscale pixels into a one-bit image by comparing each pixel against the mean of a square neighbourhood. A run-time offset is added to that mean, so software can raise or lower the threshold for the whole frame. This keeps the number of set pixels within a workable range from frame to frame. The original gray value leaves the block next to its binary decision, so both can be stored downstream.

The neighbourhood is causal. It is the k×k block whose bottom-right corner is the pixel being judged, and it is built from six line buffers plus a short history of column sums. While the binary stream is produced, set pixels are summed in non-overlapping 32×32 tiles. When a 32-line band finishes, its tiles are reported in order from left to right over a valid/ready result port. Each report carries the tile's column index, row index and count, which feed a later candidate-selection stage.

Top module: `adapt_binarizer`

## Requirements
- R1: After reset, `bin_valid` and `tile_valid` are 0.
- R2: The window code selects the window edge k: code 0 gives 3, code 1 gives 5, and codes 2 and 3 give 7. The window is the k×k block whose bottom-right pixel is the current pixel.
- R3: Let S be the window sum and N = k·k. The output bit is 1 exactly when the pixel exceeds floor(S/N) plus the unsigned 8-bit offset.
- R4: A pixel at column x or row y with x < k-1 or y < k-1 has an incomplete window and produces 0.
- R5: The window code and offset are sampled with the accepted start-of-frame pixel and hold for the rest of the frame. Changes at any other time have no effect.
- R6: Each accepted pixel produces `bin_valid` one cycle later, with `bin_pix` equal to that pixel. With no accepted pixel, `bin_valid` is 0 in the next cycle.
- R7: A tile count is the number of 1 outputs in the 32×32 region whose columns and rows start at multiples of 32. The count is 11 bits wide and never exceeds 1024.
- R8: `tile_valid` rises in the cycle after the last pixel of a band (column W-1, row 32b+31). The band's tiles then follow with `tile_x` = 0, 1, …, each handshake advancing by one, and `tile_y` = b.
- R9: While `tile_valid` is 1 and `tile_ready` is 0, the report and its fields hold steady.
- R10: A pixel flagged start-of-frame sits at (0,0). A pixel flagged end-of-line ends its row, so the next pixel starts the next row at column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of its row |
| in_pix | input | 8 | Gray value |
| cfg_win | input | 2 | Window code (R2) |
| cfg_off | input | 8 | Global threshold offset |
| bin_valid | output | 1 | Binary result valid |
| bin_bit | output | 1 | Binary decision |
| bin_pix | output | 8 | Gray value passed through |
| tile_valid | output | 1 | Tile report valid |
| tile_ready | input | 1 | Host accepts report |
| tile_x | output | TXW (1 at defaults) | Tile column index |
| tile_y | output | TYW (1 at defaults) | Tile row (band) index |
| tile_cnt | output | 11 | Set pixels in tile |

## Verification
A corrupted line buffer or column-sum history shows up as a wrong `bin_bit`, and it does so one cycle after the first pixel whose window touches the bad entry. It also shows as a wrong `tile_cnt` at the end of that band. A slipped column or row counter moves the border zeros and shifts the band-end report, so `tile_valid` rises on the wrong cycle. A lost or stuck accumulator appears in the next band's reports, at most 32 lines later. A report index that skips or repeats shows up in `tile_x` at the next handshake.

// File: rtl/abin_pkg.sv
package abin_pkg;
  localparam int PIX_W   = 8;
  localparam int MAX_DIM = 7;
  localparam int LB_ROWS = MAX_DIM - 1;
  localparam int CS_W    = PIX_W + 3;  // sum of up to 7 pixels
  localparam int WS_W    = PIX_W + 6;  // sum of up to 49 pixels
  localparam int CNT_W   = 11;
  localparam int TILE    = 32;

  // window edge selected by the run-time code
  function automatic int win_dim(input logic [1:0] code);
    case (code)
      2'd0:    return 3;
      2'd1:    return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int win_area(input logic [1:0] code);
    return win_dim(code) * win_dim(code);
  endfunction

  // pix > floor(s/n) + off  <=>  pix*n > s + off*n  (no divider needed)
  function automatic logic win_hit(input logic [PIX_W-1:0] pix,
                                   input logic [WS_W-1:0]  s,
                                   input int               n,
                                   input logic [PIX_W-1:0] off);
    logic [16:0] lhs, rhs;
    lhs = 17'(pix) * 17'(n);
    rhs = 17'(s) + 17'(off) * 17'(n);
    return lhs > rhs;
  endfunction
endpackage

// File: rtl/abin_linebuf.sv
module abin_linebuf
  import abin_pkg::*;
#(
  parameter int IMG_W = 64,
  localparam int XW = $clog2(IMG_W)
) (
  input  logic                              clk,
  input  logic                              wr_en,
  input  logic [XW-1:0]                     col,
  input  logic [PIX_W-1:0]                  pix,
  output logic [LB_ROWS-1:0][PIX_W-1:0]     above
);
  // above[j] holds row y-1-j at column col, read before this cycle's write
  for (genvar j = 0; j < LB_ROWS; j++) begin : g_row
    logic [PIX_W-1:0] mem [IMG_W];
    assign above[j] = mem[col];
    if (j == 0) begin : g_first
      always_ff @(posedge clk) if (wr_en) mem[col] <= pix;
    end else begin : g_next
      always_ff @(posedge clk) if (wr_en) mem[col] <= above[j-1];
    end
  end
endmodule

// File: rtl/abin_thresh.sv
module abin_thresh
  import abin_pkg::*;
#(
  parameter int XW = 6,
  parameter int YW = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  logic [1:0]                    code,
  input  logic [PIX_W-1:0]              off,
  input  logic [XW-1:0]                 x,
  input  logic [YW-1:0]                 y,
  input  logic [PIX_W-1:0]              pix,
  input  logic [LB_ROWS-1:0][PIX_W-1:0] above,
  output logic                          border,
  output logic                          hit
);
  logic [CS_W-1:0] csum;
  logic [CS_W-1:0] hist [LB_ROWS];
  logic [WS_W-1:0] wsum;
  int dim;

  assign dim = win_dim(code);

  always_comb begin
    csum = CS_W'(pix);
    for (int j = 0; j < LB_ROWS; j++)
      if (j < dim - 1) csum = csum + CS_W'(above[j]);
  end

  always_comb begin
    wsum = WS_W'(csum);
    for (int i = 0; i < LB_ROWS; i++)
      if (i < dim - 1) wsum = wsum + WS_W'(hist[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LB_ROWS; i++) hist[i] <= '0;
    end else if (step) begin
      hist[0] <= csum;
      for (int i = 1; i < LB_ROWS; i++) hist[i] <= hist[i-1];
    end
  end

  assign border = (int'(x) < dim - 1) || (int'(y) < dim - 1);
  assign hit    = !border && win_hit(pix, wsum, win_area(code), off);
endmodule

// File: rtl/abin_tiles.sv
module abin_tiles
  import abin_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  localparam int XW  = $clog2(IMG_W),
  localparam int YW  = $clog2(IMG_H),
  localparam int NT  = IMG_W / TILE,
  localparam int NB  = IMG_H / TILE,
  localparam int TXW = (NT > 1) ? $clog2(NT) : 1,
  localparam int TYW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [XW-1:0]    x,
  input  logic [YW-1:0]    y,
  input  logic             bit_in,
  input  logic             tile_ready,
  output logic             band_done,
  output logic             tile_valid,
  output logic [TXW-1:0]   tile_x,
  output logic [TYW-1:0]   tile_y,
  output logic [CNT_W-1:0] tile_cnt
);
  logic [CNT_W-1:0] acc [NT];
  logic [CNT_W-1:0] rep [NT];
  logic [TXW-1:0]   tx_in;

  assign tx_in     = TXW'(x >> 5);
  assign band_done = step && (int'(x) == IMG_W - 1) && (y[4:0] == 5'd31);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        acc[i] <= '0;
        rep[i] <= '0;
      end
    end else if (step) begin
      for (int i = 0; i < NT; i++) begin
        if (band_done) begin
          rep[i] <= acc[i] + CNT_W'((i == int'(tx_in)) && bit_in);
          acc[i] <= '0;
        end else if (i == int'(tx_in)) begin
          acc[i] <= acc[i] + CNT_W'(bit_in);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tile_valid <= 1'b0;
      tile_x     <= '0;
      tile_y     <= '0;
    end else if (band_done) begin
      tile_valid <= 1'b1;
      tile_x     <= '0;
      tile_y     <= TYW'(y >> 5);
    end else if (tile_valid && tile_ready) begin
      if (int'(tile_x) == NT - 1) tile_valid <= 1'b0;
      else                        tile_x     <= tile_x + 1'b1;
    end
  end

  assign tile_cnt = rep[tile_x];
endmodule

// File: rtl/adapt_binarizer.sv
module adapt_binarizer
  import abin_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  localparam int XW  = $clog2(IMG_W),
  localparam int YW  = $clog2(IMG_H),
  localparam int NT  = IMG_W / TILE,
  localparam int NB  = IMG_H / TILE,
  localparam int TXW = (NT > 1) ? $clog2(NT) : 1,
  localparam int TYW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [7:0]       in_pix,
  input  logic [1:0]       cfg_win,
  input  logic [7:0]       cfg_off,
  output logic             bin_valid,
  output logic             bin_bit,
  output logic [7:0]       bin_pix,
  output logic             tile_valid,
  input  logic             tile_ready,
  output logic [TXW-1:0]   tile_x,
  output logic [TYW-1:0]   tile_y,
  output logic [10:0]      tile_cnt
);
  logic [XW-1:0] x_cnt, cur_x;
  logic [YW-1:0] y_cnt, cur_y;
  logic [1:0]    win_q, win_eff;
  logic [7:0]    off_q, off_eff;
  logic [LB_ROWS-1:0][PIX_W-1:0] above;
  logic          pix_hit, pix_border, band_done;

  // position and frame configuration (R5, R10)
  assign cur_x   = in_sof ? '0 : x_cnt;
  assign cur_y   = in_sof ? '0 : y_cnt;
  assign win_eff = in_sof ? cfg_win : win_q;
  assign off_eff = in_sof ? cfg_off : off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_cnt <= '0;
      y_cnt <= '0;
      win_q <= '0;
      off_q <= '0;
    end else if (in_valid) begin
      x_cnt <= in_eol ? '0 : cur_x + 1'b1;
      y_cnt <= in_eol ? cur_y + 1'b1 : cur_y;
      if (in_sof) begin
        win_q <= cfg_win;
        off_q <= cfg_off;
      end
    end
  end

  abin_linebuf #(.IMG_W(IMG_W)) u_lb (
    .clk(clk), .wr_en(in_valid), .col(cur_x), .pix(in_pix), .above(above)
  );

  abin_thresh #(.XW(XW), .YW(YW)) u_thr (
    .clk(clk), .rst_n(rst_n), .step(in_valid), .code(win_eff), .off(off_eff),
    .x(cur_x), .y(cur_y), .pix(in_pix), .above(above),
    .border(pix_border), .hit(pix_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_valid <= 1'b0;
      bin_bit   <= 1'b0;
      bin_pix   <= '0;
    end else begin
      bin_valid <= in_valid;
      if (in_valid) begin
        bin_bit <= pix_hit;
        bin_pix <= in_pix;
      end
    end
  end

  abin_tiles #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_tiles (
    .clk(clk), .rst_n(rst_n), .step(in_valid), .x(cur_x), .y(cur_y),
    .bit_in(pix_hit), .tile_ready(tile_ready), .band_done(band_done),
    .tile_valid(tile_valid), .tile_x(tile_x), .tile_y(tile_y), .tile_cnt(tile_cnt)
  );
endmodule

// File: rtl/abin_checker.sv
module abin_checker #(
  parameter int TXW = 1,
  parameter int TYW = 1,
  parameter int NT  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [7:0]     in_pix,
  input logic           bin_valid,
  input logic [7:0]     bin_pix,
  input logic           tile_valid,
  input logic           tile_ready,
  input logic [TXW-1:0] tile_x,
  input logic [TYW-1:0] tile_y,
  input logic [10:0]    tile_cnt,
  input logic           band_done
);
  assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> bin_valid && (bin_pix == $past(in_pix)));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !bin_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tile_valid && !tile_ready && !band_done |=>
      tile_valid && $stable(tile_x) && $stable(tile_y) && $stable(tile_cnt));

  assert_band_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    band_done |=> tile_valid && (tile_x == '0));

  assert_next_tile_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tile_valid && tile_ready && (int'(tile_x) != NT - 1) && !band_done |=>
      tile_valid && (tile_x == $past(tile_x) + 1'b1));

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tile_valid |-> (tile_cnt <= 11'd1024));
endmodule

bind adapt_binarizer abin_checker #(.TXW(TXW), .TYW(TYW), .NT(NT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
  .bin_valid(bin_valid), .bin_pix(bin_pix), .tile_valid(tile_valid),
  .tile_ready(tile_ready), .tile_x(tile_x), .tile_y(tile_y),
  .tile_cnt(tile_cnt), .band_done(band_done)
);

// File: tb/tb_adapt_binarizer.sv
module tb_adapt_binarizer;
  localparam int W = 64, H = 64, NT = W / 32, NB = H / 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eol = 0;
  logic [7:0] in_pix = 0, cfg_off = 0;
  logic [1:0] cfg_win = 0;
  logic tile_ready = 0;
  logic bin_valid, bin_bit, tile_valid;
  logic [7:0] bin_pix;
  logic [0:0] tile_x, tile_y;
  logic [10:0] tile_cnt;

  int total = 0, bad = 0;
  int img [H][W];
  bit ebit [H][W];
  int ecnt [NB][NT];
  int seen = 0;

  always #5 clk = ~clk;

  adapt_binarizer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_pix(in_pix), .cfg_win(cfg_win), .cfg_off(cfg_off), .bin_valid(bin_valid),
    .bin_bit(bin_bit), .bin_pix(bin_pix), .tile_valid(tile_valid), .tile_ready(tile_ready),
    .tile_x(tile_x), .tile_y(tile_y), .tile_cnt(tile_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: k from code (R2), border zero (R4), mean by division (R3)
  function automatic bit ref_bit(int x, int y, int code, int off);
    int k, s;
    k = (code == 0) ? 3 : (code == 1) ? 5 : 7;
    if (x < k - 1 || y < k - 1) return 0;
    s = 0;
    for (int dy = 0; dy < k; dy++)
      for (int dx = 0; dx < k; dx++) s += img[y-dy][x-dx];
    return img[y][x] > (s / (k * k)) + off;
  endfunction

  task automatic build(int pat, int code, int off);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        case (pat)
          0: img[y][x] = $urandom % 256;
          1: img[y][x] = 0;
          2: img[y][x] = ($urandom % 40 == 0) ? 200 + $urandom % 56 : 90 + $urandom % 21;
          3: img[y][x] = x * 4;
          default: img[y][x] = 255;
        endcase
    for (int b = 0; b < NB; b++) for (int t = 0; t < NT; t++) ecnt[b][t] = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        ebit[y][x] = ref_bit(x, y, code, off);
        ecnt[y/32][x/32] += int'(ebit[y][x]);  // R7
      end
  endtask

  task automatic run_frame(int pat, int code, int off, bit scramble);
    build(pat, code, off);
    seen = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if ($urandom % 5 == 0) begin
          @(negedge clk); in_valid = 0;
          @(posedge clk); #1;
          chk(!bin_valid, "R6 idle", int'(bin_valid), 0);
        end
        @(negedge clk);
        in_valid = 1; in_pix = 8'(img[y][x]);
        in_sof = (x == 0 && y == 0); in_eol = (x == W - 1);
        if (in_sof) begin
          cfg_win = 2'(code); cfg_off = 8'(off);
        end else if (scramble) begin
          cfg_win = 2'($urandom); cfg_off = 8'($urandom);  // R5: ignored mid-frame
        end
        @(posedge clk); #1;
        chk(bin_valid && bin_pix == 8'(img[y][x]), "R6 pass", int'(bin_pix), img[y][x]);
        chk(bin_bit == ebit[y][x], "R3/R4/R5 bit", int'(bin_bit), int'(ebit[y][x]));
      end
    @(negedge clk); in_valid = 0; in_sof = 0; in_eol = 0;
    repeat (30) @(posedge clk);
    #1 chk(seen == NB * NT, "R8 report total", seen, NB * NT);
  endtask

  // host side: random ready, check each accepted report (R7, R8, R9)
  initial begin
    forever begin
      @(negedge clk);
      tile_ready = ($urandom % 4 != 0);
      #1;
      if (rst_n && tile_valid && tile_ready) begin
        if (seen >= NB * NT) chk(0, "R8 extra report", seen, NB * NT);
        else begin
          chk(int'(tile_x) == seen % NT, "R8 tile_x", int'(tile_x), seen % NT);
          chk(int'(tile_y) == seen / NT, "R8 tile_y", int'(tile_y), seen / NT);
          chk(int'(tile_cnt) == ecnt[seen/NT][seen%NT], "R7 count",
              int'(tile_cnt), ecnt[seen/NT][seen%NT]);
        end
        seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1 chk(!bin_valid && !tile_valid, "R1 reset", int'({bin_valid, tile_valid}), 0);
    @(negedge clk); rst_n = 1;
    run_frame(3, 0, 0, 0);     // ramp: R4 border, R7 full tile 1024
    run_frame(2, 0, 10, 1);    // sparse spots, 3x3, R5 scramble
    run_frame(0, 1, 0, 1);     // random, 5x5
    run_frame(2, 2, 5, 0);     // 7x7
    run_frame(0, 3, 0, 1);     // code 3 behaves as 7x7 (R2)
    run_frame(1, 1, 0, 0);     // flat zero: nothing set
    run_frame(4, 0, 0, 0);     // flat white: equal to mean, nothing set
    run_frame(0, 0, 255, 0);   // maximum offset
    run_frame(0, 0, 3, 1);     // random, 3x3
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule